// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is a purely combinational integer arithmetic and logic unit of parameterised width (32 bits by default). A 3-bit operation code chooses one of five operations on two operands: bitwise AND, bitwise OR, addition, subtraction and set-on-less-than. Alongside the result it reports four condition flags: zero, overflow, carry-out and sign. Operands are two's complement, so an N-bit operand covers -2^(N-1) through 2^(N-1)-1.

Subtraction does not need a second adder. The same ripple adder is used, with B inverted and the carry-in forced to one, so it computes A + ~B + 1. Set-on-less-than runs that subtraction and returns only the sign bit of the difference, placed in bit 0. Signed overflow is found at the top bit of the adder, as the carry entering the MSB XOR the carry leaving it. A small decoder turns the operation code into a set of strobes for the datapath.

Top module: `alu_core`

## Requirements
- R1: Code 3'b000 returns A & B and code 3'b001 returns A | B. For both, carry and overflow are 0.
- R2: Code 3'b010 returns (A + B) mod 2^N.
- R3: Code 3'b110 returns (A - B) mod 2^N, computed as A + ~B + 1.
- R4: Code 3'b111 puts bit N-1 of (A - B) mod 2^N in result bit 0 and clears every other result bit. No overflow correction is applied. For this code, carry and overflow are 0.
- R5: For a valid code, zero is 1 exactly when every result bit is 0.
- R6: For add and subtract, overflow is 1 exactly when the true signed result lies outside -2^(N-1)..2^(N-1)-1.
- R7: For add, carry is bit N of A + B. For subtract, carry is bit N of A + ~B + 1, which is 1 exactly when A >= B unsigned.
- R8: For a valid code, sign equals result bit N-1.
- R9: Codes 3'b011, 3'b100 and 3'b101 drive the result to 0 and clear all four flags, including zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| opSel | input | 3 | Operation code |
| result | output | WIDTH | Operation result |
| zeroFlag | output | 1 | Result is all zeros (valid code only) |
| ovfFlag | output | 1 | Signed overflow of add or subtract |
| carryFlag | output | 1 | Carry out of the MSB for add or subtract |
| signFlag | output | 1 | Result MSB (valid code only) |

## Verification
The block has no state, so a wrong decode strobe or a broken carry link shows at the ports in the same evaluation that applies the operands. Nothing is stored that could hide a fault until later. A fault in one carry link only shows when a carry has to pass through that link. For that reason, a 4-bit build is swept over every operand pair and every code. This reaches every carry path, the most negative value, -1 and 0, and every mixed-sign comparison. A 32-bit build is then driven with a set of extreme operands, to confirm that the carry chain and the overflow tap work at full width.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;
  typedef enum logic [2:0] {
    OP_AND = 3'b000,
    OP_OR  = 3'b001,
    OP_ADD = 3'b010,
    OP_SUB = 3'b110,
    OP_SLT = 3'b111
  } aluOp_e;

  typedef struct packed {
    logic andSel;    // bitwise AND drives result
    logic orSel;     // bitwise OR drives result
    logic sumSel;    // adder sum drives result
    logic sltSel;    // adder sign drives result bit 0
    logic invertB;   // invert B and force carry-in
    logic arithFlag; // carry and overflow are reported
    logic validOp;   // code is one of the five defined
  } aluCtrl_t;
endpackage

// File: rtl/alu_ctrl.sv
`timescale 1ns/1ps
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [2:0] opSel,
  output aluCtrl_t   ctrl
);
  always_comb begin
    ctrl = '0;
    case (opSel)
      OP_AND: begin ctrl.andSel = 1'b1; ctrl.validOp = 1'b1; end
      OP_OR:  begin ctrl.orSel  = 1'b1; ctrl.validOp = 1'b1; end
      OP_ADD: begin
        ctrl.sumSel = 1'b1; ctrl.arithFlag = 1'b1; ctrl.validOp = 1'b1;
      end
      OP_SUB: begin
        ctrl.sumSel = 1'b1; ctrl.invertB = 1'b1;
        ctrl.arithFlag = 1'b1; ctrl.validOp = 1'b1;
      end
      OP_SLT: begin
        ctrl.sltSel = 1'b1; ctrl.invertB = 1'b1; ctrl.validOp = 1'b1;
      end
      default: ctrl = '0;
    endcase
    AST_ONE_RESULT_SOURCE: assert ($onehot0({ctrl.andSel, ctrl.orSel, ctrl.sumSel, ctrl.sltSel}))
      else $error("more than one result source selected"); // R1
  end
endmodule

// File: rtl/alu_adder.sv
`timescale 1ns/1ps
module alu_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] addA,
  input  logic [WIDTH-1:0] addB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sum,
  output logic             carryIntoMsb,
  output logic             carryOut
);
  logic [WIDTH:0] carryChain;
  assign carryChain[0] = carryIn;

  for (genvar bitIdx = 0; bitIdx < WIDTH; bitIdx++) begin : g_bitCell
    assign sum[bitIdx] = addA[bitIdx] ^ addB[bitIdx] ^ carryChain[bitIdx];
    assign carryChain[bitIdx+1] = (addA[bitIdx] & addB[bitIdx]) |
                                  (carryChain[bitIdx] & (addA[bitIdx] ^ addB[bitIdx]));
  end

  assign carryIntoMsb = carryChain[WIDTH-1];
  assign carryOut     = carryChain[WIDTH];

  always_comb begin
    AST_ADDER_MATCHES_WIDE_SUM: assert ({carryOut, sum} ==
        ({1'b0, addA} + {1'b0, addB} + {{WIDTH{1'b0}}, carryIn}))
      else $error("ripple chain disagrees with wide sum"); // R2
  end
endmodule

// File: rtl/alu_datapath.sv
`timescale 1ns/1ps
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluCtrl_t         ctrl,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             ovfFlag,
  output logic             carryFlag,
  output logic             signFlag
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] adderB;
  logic [WIDTH-1:0] sum;
  logic             carryIntoMsb;
  logic             carryOut;

  assign adderB = ctrl.invertB ? ~opB : opB;

  alu_adder #(.WIDTH(WIDTH)) adder_i (
    .addA        (opA),
    .addB        (adderB),
    .carryIn     (ctrl.invertB),
    .sum         (sum),
    .carryIntoMsb(carryIntoMsb),
    .carryOut    (carryOut)
  );

  always_comb begin
    result = '0;
    if (ctrl.andSel) result = opA & opB;
    if (ctrl.orSel)  result = opA | opB;
    if (ctrl.sumSel) result = sum;
    if (ctrl.sltSel) result = {{(WIDTH-1){1'b0}}, sum[MSB]};

    zeroFlag  = ctrl.validOp & ~(|result);
    signFlag  = ctrl.validOp & result[MSB];
    carryFlag = ctrl.arithFlag & carryOut;
    ovfFlag   = ctrl.arithFlag & (carryIntoMsb ^ carryOut);

    AST_SLT_UPPER_CLEAR: assert (!ctrl.sltSel || ((result >> 1) == '0))
      else $error("compare result has upper bits set"); // R4
    AST_UNUSED_QUIET: assert (ctrl.validOp ||
        (result == '0 && !zeroFlag && !ovfFlag && !carryFlag && !signFlag))
      else $error("unused code produced output"); // R9
    AST_LOGIC_NO_ARITH_FLAGS: assert (!(ctrl.andSel || ctrl.orSel) || (!carryFlag && !ovfFlag))
      else $error("logic op raised carry or overflow"); // R1
  end
endmodule

// File: rtl/alu_core.sv
`timescale 1ns/1ps
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [2:0]       opSel,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             ovfFlag,
  output logic             carryFlag,
  output logic             signFlag
);
  aluCtrl_t ctrl;

  alu_ctrl ctrl_i (
    .opSel(opSel),
    .ctrl (ctrl)
  );

  alu_datapath #(.WIDTH(WIDTH)) datapath_i (
    .opA      (opA),
    .opB      (opB),
    .ctrl     (ctrl),
    .result   (result),
    .zeroFlag (zeroFlag),
    .ovfFlag  (ovfFlag),
    .carryFlag(carryFlag),
    .signFlag (signFlag)
  );
endmodule

// File: tb/alu_core_tb_top.sv
`timescale 1ns/1ps
module alu_core_tb_top;
  localparam int NW = 4;
  localparam int WW = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk; // 8 ns period, 125 MHz

  logic [NW-1:0] aN, bN, resN;
  logic [2:0]    selN;
  logic          zN, vN, cN, sN;
  logic [WW-1:0] aW, bW, resW;
  logic [2:0]    selW;
  logic          zW, vW, cW, sW;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  alu_core #(.WIDTH(NW)) dut_i (
    .opA(aN), .opB(bN), .opSel(selN), .result(resN),
    .zeroFlag(zN), .ovfFlag(vN), .carryFlag(cN), .signFlag(sN)
  );

  alu_core #(.WIDTH(WW)) dutWide_i (
    .opA(aW), .opB(bW), .opSel(selW), .result(resW),
    .zeroFlag(zW), .ovfFlag(vW), .carryFlag(cW), .signFlag(sW)
  );

  function automatic string reqOf(input int op);
    case (op)
      0, 1: return "R1";
      2: return "R2/R6/R7";
      6: return "R3/R6/R7";
      7: return "R4";
      default: return "R9";
    endcase
  endfunction

  // Independent arithmetic model. Returns {res, zero, ovf, carry, sign} for width w.
  function automatic logic [67:0] model(input longint a, input longint b, input int op, input int w);
    longint mask, half, sa, sb, full, res;
    logic z, v, c, s, valid;
    mask = (longint'(1) << w) - 1;
    half = longint'(1) << (w - 1);
    sa = (a >= half) ? a - (half << 1) : a;
    sb = (b >= half) ? b - (half << 1) : b;
    res = 0; v = 0; c = 0; valid = 1;
    case (op)
      0: res = a & b;
      1: res = a | b;
      2: begin
        full = a + b; res = full & mask; c = full[w];
        v = (sa + sb > half - 1) || (sa + sb < -half);
      end
      6: begin
        full = a + ((~b) & mask) + 1; res = full & mask; c = (a >= b);
        v = (sa - sb > half - 1) || (sa - sb < -half);
      end
      7: res = (((a - b) & mask) >> (w - 1)) & 1;
      default: valid = 0;
    endcase
    z = valid && (res == 0);
    s = valid && res[w-1];
    return {res[63:0], z, v, c, s};
  endfunction

  task automatic checkNarrow(input int a, input int b, input int op);
    logic [67:0] exp;
    logic [67:0] got;
    @(posedge clk);
    aN = a[NW-1:0]; bN = b[NW-1:0]; selN = op[2:0];
    @(negedge clk);
    exp = model(longint'(a), longint'(b), op, NW);
    got = {60'd0, resN, zN, vN, cN, sN};
    testsRun++;
    if (got != exp) begin
      testsFailed++;
      $display("FAIL %s N=4 a=%0d b=%0d op=%0d actual=%h expected=%h (res,z,v,c,s)",
               reqOf(op), a, b, op, got, exp);
    end
  endtask

  task automatic checkWide(input logic [WW-1:0] a, input logic [WW-1:0] b, input int op);
    logic [67:0] exp;
    logic [67:0] got;
    @(posedge clk);
    aW = a; bW = b; selW = op[2:0];
    @(negedge clk);
    exp = model(longint'(a), longint'(b), op, WW);
    got = {32'd0, resW, zW, vW, cW, sW};
    testsRun++;
    if (got != exp) begin
      testsFailed++;
      $display("FAIL %s N=32 a=%h b=%h op=%0d actual=%h expected=%h (res,z,v,c,s)",
               reqOf(op), a, b, op, got, exp);
    end
  endtask

  logic [WW-1:0] corners [6] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000,
                                 32'h7FFF_FFFF, 32'h1234_5678};

  initial begin
    aN = '0; bN = '0; selN = 3'b011; aW = '0; bW = '0; selW = 3'b011;
    // Initial state: unused code, all outputs quiet (R9)
    @(negedge clk);
    testsRun++;
    if ({resN, zN, vN, cN, sN} != '0) begin
      testsFailed++;
      $display("FAIL R9 initial actual=%h expected=0", {resN, zN, vN, cN, sN});
    end
    // Exhaustive 4-bit sweep: R1..R9 incl. -8, -1, 0 and mixed-sign compares (R4, R5, R8)
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          checkNarrow(a, b, op);
    // Full-width extremes: R2, R3, R4, R6, R7, R9
    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          checkWide(corners[i], corners[j], op);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule